// File: doc/BRIEF.md
# Single-Precision Float to 32-bit Integer Converter

This block turns a packed binary32 operand into a 32-bit integer. The result can be either two's-complement signed or unsigned, chosen per operation. Rounding follows a 2-bit rounding-mode input. A truncating control overrides that input and rounds toward zero, which is what a language-level cast needs.

Alongside the integer the block reports three flags. Invalid is raised for NaNs, out-of-range values and negative values in unsigned mode. Inexact is raised when fraction bits were discarded. Input-denormal is raised when the operand was subnormal. Results that cannot be represented saturate, and how they saturate depends on the signedness. Operands of magnitude below one-half take a short path of their own, where directed rounding can still produce 1 or -1.

The converter is a single stage. An operand presented with `in_valid` produces its result and flags, together with `out_valid`, one clock later. The result holds until the next valid operand.

Top module: `f2i_convert`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. A synchronous active-low reset clears `out_valid`, `out_int` and all flags to 0, whatever the inputs do during reset.
- R2: `rmode` encodes 00 = nearest-even, 01 = toward +infinity, 10 = toward -infinity and 11 = toward zero. When `trunc_mode` is 1, `rmode` is ignored and toward zero is used.
- R3: `out_denorm` is 1 exactly when the exponent field (bits 30:23) is 0 and the fraction (bits 22:0) is non-zero.
- R4: A non-NaN operand with an exponent field of 159 or more, infinities included, sets invalid and clears inexact. The signed result is 0x7FFFFFFF if the operand is positive and 0x80000000 if it is negative. The unsigned result is 0xFFFFFFFF if the operand is positive and 0 if it is negative.
- R5: A NaN operand (exponent field 255, fraction non-zero) sets invalid. It gives 0 in signed mode and 0xFFFFFFFF in unsigned mode, because its sign is taken as positive.
- R6: For exponent fields 126 to 158, the result is the operand rounded to an integer in the selected mode. Inexact is set exactly when the discarded fraction is non-zero and invalid is not raised.
- R7: In signed mode, a rounded value above 2^31-1 gives 0x7FFFFFFF and one below -2^31 gives 0x80000000, each with invalid and without inexact. Exactly -2^31 converts without flags.
- R8: In unsigned mode, a negative operand in the exponent range 126 to 158 that rounds to a non-zero magnitude gives 0 with invalid and without inexact. One that rounds to zero gives 0, with inexact set if a fraction was discarded.
- R9: An operand with an exponent field below 126 gives 0, with inexact if it is non-zero. Toward +infinity on a positive non-zero operand gives 1. Toward -infinity on a negative non-zero operand gives 0xFFFFFFFF (-1) in signed mode, and 0 with both invalid and inexact in unsigned mode.
- R10: Positive and negative zero give 0 with invalid and inexact clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_bits | input | 32 | Packed binary32 operand |
| signed_mode | input | 1 | 1 = signed result, 0 = unsigned result |
| trunc_mode | input | 1 | 1 = force rounding toward zero |
| rmode | input | 2 | Rounding mode (R2 encoding) |
| out_valid | output | 1 | Result valid |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |

## Verification
The bench targets the ties at exactly one-half in nearest mode, where a design that ignores the integer's parity would round 2.5 up to 3. It exercises the signed limit at 2^31, where an off-by-one clamp would either reject -2^31 or accept +2^31. It covers negative operands in unsigned mode, where a design that checks the sign before rounding would wrongly flag -0.3, and one that checks after rounding but forgets the suppression would report inexact together with invalid. It also drives NaNs of both signs, sub-half values under directed rounding (a missing path would return 0 instead of 1 or -1), and truncating operations with a non-zero `rmode` that must not leak into the result.

// File: rtl/f2i_pkg.sv
// Package: format constants and rounding-mode encoding shared by the
// converter, its sub-blocks and its checker. Assumes a binary interchange
// float with a hidden leading one and an integer no wider than the shifter.
package f2i_pkg;
    parameter int EXP_W    = 8;
    parameter int FRAC_W   = 23;
    parameter int INT_W    = 32;
    localparam int FLT_W    = 1 + EXP_W + FRAC_W;
    localparam int MANT_W   = FRAC_W + 1;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_SAT  = BIAS + INT_W;   // first exponent that always saturates
    localparam int EXP_HALF = BIAS - 1;       // exponent of values in [0.5, 1)
    localparam int SH_W     = $clog2(INT_W) + 2;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;
endpackage

// File: rtl/f2i_classify.sv
// Module: splits the operand into special-value classes and the significand
// with its hidden bit restored. Assumes the hidden bit is 1 only for
// non-zero exponents that are not all ones.
module f2i_classify
    import f2i_pkg::*;
(
    input  logic [FLT_W-1:0]  op_bits,
    output logic              is_nan,
    output logic              is_zero,
    output logic              is_denorm,
    output logic [MANT_W-1:0] mant
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_min, exp_max;

    // Decode the operand fields into classes.
    always_comb begin
        exp_f     = op_bits[FLT_W-2:FRAC_W];
        frac_f    = op_bits[FRAC_W-1:0];
        exp_min   = (exp_f == '0);
        exp_max   = (exp_f == '1);
        is_nan    = exp_max && (frac_f != '0);
        is_zero   = exp_min && (frac_f == '0);
        is_denorm = exp_min && (frac_f != '0);
        mant      = {!exp_min && !exp_max, frac_f};
    end
endmodule

// File: rtl/f2i_align.sv
// Module: places the significand so that the integer part and a full-width
// remainder come out of one right shift. Assumes the exponent lies between
// EXP_HALF and EXP_SAT-1; outputs outside that range are don't-care.
module f2i_align
    import f2i_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_f,
    input  logic [MANT_W-1:0] mant,
    output logic [INT_W-1:0]  ipart,
    output logic [INT_W-1:0]  rem
);
    localparam int WIDE_W = 2 * INT_W;
    logic [SH_W-1:0]   sh;
    logic [WIDE_W-1:0] wide;

    // Shift the left-justified significand down by the distance to the top exponent.
    always_comb begin
        sh    = SH_W'((EXP_SAT - 1) - int'(exp_f));
        wide  = {mant, {(WIDE_W - MANT_W){1'b0}}} >> sh;
        ipart = wide[WIDE_W-1:INT_W];
        rem   = wide[INT_W-1:0];
    end
endmodule

// File: rtl/f2i_round_carry.sv
// Module: forms the rounding increment for the selected mode and reports
// whether adding it to the remainder carries into the integer part.
// Assumes the remainder's top bit weighs one-half.
module f2i_round_carry
    import f2i_pkg::*;
(
    input  rmode_e            rm,
    input  logic              neg,
    input  logic              ipart_lsb,
    input  logic [INT_W-1:0]  rem,
    output logic              carry
);
    localparam logic [INT_W-1:0] HALF  = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] BELOW = {1'b0, {(INT_W-1){1'b1}}};
    logic [INT_W-1:0] incr;
    logic [INT_W:0]   sum;

    // Pick the increment and detect the carry out of remainder plus increment.
    always_comb begin
        case (rm)
            RM_NEAR: incr = ipart_lsb ? HALF : BELOW;
            RM_UP:   incr = neg ? '0 : '1;
            RM_DOWN: incr = neg ? '1 : '0;
            default: incr = '0;
        endcase
        sum   = {1'b0, rem} + {1'b0, incr};
        carry = sum[INT_W];
    end
endmodule

// File: rtl/f2i_convert.sv
// Module: top of the float-to-integer converter. Selects among the NaN,
// saturating, in-range and sub-half paths, applies signedness rules and
// registers result and flags. Assumes one operand per cycle at most.
module f2i_convert
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLT_W-1:0]  in_bits,
    input  logic              signed_mode,
    input  logic              trunc_mode,
    input  logic [1:0]        rmode,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_int,
    output logic              out_invalid,
    output logic              out_inexact,
    output logic              out_denorm
);
    localparam logic [INT_W-1:0] ALL1 = '1;
    localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

    logic              is_nan, is_zero, is_denorm, carry, neg;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  exp_f;
    logic [INT_W-1:0]  ipart, rem, res_d, lim;
    logic              inv_d, inx_d;
    rmode_e            rm_eff;

    f2i_classify u_class (
        .op_bits(in_bits), .is_nan(is_nan), .is_zero(is_zero),
        .is_denorm(is_denorm), .mant(mant)
    );

    f2i_align u_align (
        .exp_f(exp_f), .mant(mant), .ipart(ipart), .rem(rem)
    );

    f2i_round_carry u_round (
        .rm(rm_eff), .neg(neg), .ipart_lsb(ipart[0]), .rem(rem), .carry(carry)
    );

    // Effective rounding mode, exponent field and sign after NaN handling.
    always_comb begin
        rm_eff = trunc_mode ? RM_ZERO : rmode_e'(rmode);
        exp_f  = in_bits[FLT_W-2:FRAC_W];
        neg    = in_bits[FLT_W-1] && !(is_nan && !signed_mode);
    end

    // Select the integer result and the invalid and inexact flags.
    always_comb begin
        res_d = '0;
        inv_d = 1'b0;
        inx_d = 1'b0;
        lim   = neg ? SMIN : SMAX;
        if (signed_mode && is_nan) begin
            inv_d = 1'b1;
        end else if (exp_f >= EXP_W'(EXP_SAT)) begin
            inv_d = 1'b1;
            if (signed_mode) res_d = lim;
            else             res_d = neg ? '0 : ALL1;
        end else if (exp_f >= EXP_W'(EXP_HALF)) begin
            res_d = ipart;
            if (carry) begin
                if (ipart != ALL1) res_d = ipart + INT_W'(1);
                else if (!signed_mode) inv_d = 1'b1;
            end
            if (!signed_mode) begin
                if (neg && res_d != '0) begin
                    res_d = '0;
                    inv_d = 1'b1;
                end else if (rem != '0) begin
                    inx_d = 1'b1;
                end
            end else begin
                if (res_d > lim) begin
                    res_d = lim;
                    inv_d = 1'b1;
                end else if (rem != '0) begin
                    inx_d = 1'b1;
                end
                if (neg) res_d = INT_W'(0) - res_d;
            end
        end else if (!is_zero) begin
            inx_d = 1'b1;
            if (rm_eff == RM_UP && !neg) begin
                res_d = INT_W'(1);
            end else if (rm_eff == RM_DOWN && neg) begin
                if (signed_mode) res_d = ALL1;
                else             inv_d = 1'b1;
            end
        end
    end

    // Output register: valid follows input valid, data loads on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            out_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_int     <= res_d;
                out_invalid <= inv_d;
                out_inexact <= inx_d;
                out_denorm  <= is_denorm;
            end
        end
    end
endmodule

// File: rtl/f2i_convert_chk.sv
// Module: property checker for the converter, attached by bind. Relates the
// operand seen with in_valid to the registered outputs one cycle later.
module f2i_convert_chk
    import f2i_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [FLT_W-1:0] in_bits,
    input logic             signed_mode,
    input logic             out_valid,
    input logic [INT_W-1:0] out_int,
    input logic             out_invalid,
    input logic             out_inexact,
    input logic             out_denorm
);
    localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
    logic [EXP_W-1:0] exp_f;
    logic             op_nan, op_zero, op_sub;

    // Operand classes seen by the checker.
    always_comb begin
        exp_f   = in_bits[FLT_W-2:FRAC_W];
        op_nan  = (exp_f == '1) && (in_bits[FRAC_W-1:0] != '0);
        op_zero = (in_bits[FLT_W-2:0] == '0);
        op_sub  = (exp_f == '0) && (in_bits[FRAC_W-1:0] != '0);
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    denorm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_denorm == $past(op_sub)));
    // R5
    nan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_nan) |=> (out_invalid && !out_inexact));
    // R4
    pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && signed_mode && !op_nan && !in_bits[FLT_W-1] && exp_f >= EXP_W'(EXP_SAT))
        |=> (out_int == SMAX && out_invalid));
    // R8
    unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !signed_mode && !op_nan && in_bits[FLT_W-1]) |=> (out_int == '0));
    // R10
    zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_zero) |=> (out_int == '0 && !out_invalid && !out_inexact));
endmodule

bind f2i_convert f2i_convert_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .signed_mode(signed_mode), .out_valid(out_valid), .out_int(out_int),
    .out_invalid(out_invalid), .out_inexact(out_inexact), .out_denorm(out_denorm)
);

// File: tb/f2i_convert_bench.sv
`timescale 1ns/1ps
module f2i_convert_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        signed_mode = 1'b0;
    logic        trunc_mode = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic        out_valid, out_invalid, out_inexact, out_denorm;
    logic [31:0] out_int;

    typedef struct {
        logic [31:0] r;
        bit inv;
        bit inx;
        bit dn;
        string tag;
    } expect_t;

    expect_t q[$];
    int  vectors = 0;
    int  miscompares = 0;
    bit  prev_valid = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    f2i_convert u_f2i_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .signed_mode(signed_mode), .trunc_mode(trunc_mode), .rmode(rmode),
        .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .out_denorm(out_denorm)
    );

    // Behavioural reference: exact value arithmetic on 64-bit integers.
    function automatic expect_t model(logic [31:0] a, bit sg, bit tr, logic [1:0] rm);
        expect_t m;
        int e, nb;
        longint mant, ip, frm, half, mag, v;
        bit s, frnz, gt, eq, up;
        logic [1:0] rme;
        e = int'(a[30:23]);
        s = a[31];
        m.r = '0; m.inv = 0; m.inx = 0;
        m.dn = (e == 0) && (a[22:0] != 0);
        rme = tr ? 2'b11 : rm;
        if (e == 255 && a[22:0] != 0) begin
            m.r = sg ? 32'h0 : 32'hFFFF_FFFF; m.inv = 1; m.tag = "R5";
            return m;
        end
        if (e >= 159) begin
            m.inv = 1; m.tag = "R4";
            if (sg) m.r = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else    m.r = s ? 32'h0 : 32'hFFFF_FFFF;
            return m;
        end
        mant = (e != 0) ? ((longint'(1) << 23) | longint'(a[22:0])) : longint'(a[22:0]);
        nb   = (e != 0) ? 150 - e : 149;
        gt = 0; eq = 0;
        if (nb <= 0) begin
            ip = mant << (-nb); frnz = 0;
        end else if (nb >= 25) begin
            ip = 0; frnz = (mant != 0);
        end else begin
            ip   = mant >> nb;
            frm  = mant & ((longint'(1) << nb) - 1);
            half = longint'(1) << (nb - 1);
            frnz = (frm != 0); gt = (frm > half); eq = (frm == half);
        end
        case (rme)
            2'b00:   up = gt || (eq && (ip % 2 == 1));
            2'b01:   up = frnz && !s;
            2'b10:   up = frnz && s;
            default: up = 0;
        endcase
        mag = ip + (up ? 1 : 0);
        v   = s ? -mag : mag;
        m.inx = frnz;
        if (sg) begin
            if (v > 64'sd2147483647)       begin m.r = 32'h7FFF_FFFF; m.inv = 1; end
            else if (v < -64'sd2147483648) begin m.r = 32'h8000_0000; m.inv = 1; end
            else m.r = 32'(v);
        end else begin
            if (v < 0)                     begin m.r = 32'h0; m.inv = 1; end
            else if (v > 64'sd4294967295)  begin m.r = 32'hFFFF_FFFF; m.inv = 1; end
            else m.r = 32'(v);
        end
        if (m.inv && e >= 126) m.inx = 0;
        if (a[30:0] == 0)        m.tag = "R10";
        else if (e < 126)        m.tag = "R9";
        else if (!sg && s)       m.tag = "R8";
        else if (sg && m.inv)    m.tag = "R7";
        else if (tr)             m.tag = "R2";
        else                     m.tag = "R6";
        return m;
    endfunction

    // Compare the outputs of this cycle with the reference queue.
    task automatic check_cycle();
        expect_t x;
        vectors++;
        if (out_valid !== prev_valid) begin
            miscompares++;
            $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, prev_valid);
        end
        if (out_valid && q.size() > 0) begin
            x = q.pop_front();
            vectors++;
            if (out_int !== x.r || out_invalid !== x.inv || out_inexact !== x.inx) begin
                miscompares++;
                $display("FAIL %s int/inv/inx act=%08h/%0b/%0b exp=%08h/%0b/%0b",
                         x.tag, out_int, out_invalid, out_inexact, x.r, x.inv, x.inx);
            end
            vectors++;
            if (out_denorm !== x.dn) begin
                miscompares++;
                $display("FAIL R3 denorm act=%0b exp=%0b", out_denorm, x.dn);
            end
        end
    endtask

    task automatic drive(logic [31:0] a, bit sg, bit tr, logic [1:0] rm);
        @(negedge clk);
        check_cycle();
        in_valid = 1'b1; in_bits = a; signed_mode = sg; trunc_mode = tr; rmode = rm;
        q.push_back(model(a, sg, tr, rm));
        prev_valid = 1'b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_cycle();
            in_valid = 1'b0;
            in_bits = $urandom;
            prev_valid = 1'b0;
        end
    endtask

    // Drive both signednesses and all four modes for one operand.
    task automatic sweep(logic [31:0] a);
        for (int sg = 0; sg < 2; sg++)
            for (int rm = 0; rm < 4; rm++)
                drive(a, sg[0], 1'b0, rm[1:0]);
    endtask

    initial begin
        logic [31:0] a;
        // R1: valid activity during reset must not reach the outputs.
        in_valid = 1'b1; in_bits = 32'h3F80_0000;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        vectors++;
        if (out_valid !== 0 || out_int !== 0 || out_invalid !== 0 || out_inexact !== 0 || out_denorm !== 0) begin
            miscompares++;
            $display("FAIL R1 reset state act=%0b/%08h/%0b/%0b/%0b exp=0/00000000/0/0/0",
                     out_valid, out_int, out_invalid, out_inexact, out_denorm);
        end
        // R6 ties and plain values, R7 signed limits, R4 saturation.
        sweep(32'h3F80_0000); sweep(32'h4020_0000); sweep(32'h4060_0000);
        sweep(32'hC020_0000); sweep(32'h3FC0_0000); sweep(32'hBFC0_0000);
        sweep(32'h4F00_0000); sweep(32'hCF00_0000); sweep(32'h4F7F_FFFF);
        sweep(32'h4F80_0000); sweep(32'hCF80_0000); sweep(32'h7F80_0000); sweep(32'hFF80_0000);
        // R5 NaNs of both signs and kinds.
        sweep(32'h7FC0_0000); sweep(32'hFFC0_0000); sweep(32'h7F80_0001);
        // R9 sub-half values and R3 denormals, R10 zeros.
        sweep(32'h3E80_0000); sweep(32'hBE80_0000); sweep(32'h3F00_0000); sweep(32'hBF00_0000);
        sweep(32'h0000_0001); sweep(32'h8000_0001); sweep(32'h0000_0000); sweep(32'h8000_0000);
        // R8 negative values in unsigned mode.
        sweep(32'hBF33_3333); sweep(32'hBE99_999A);
        // R2 truncating variants with every rmode value.
        for (int rm = 0; rm < 4; rm++) begin
            drive(32'h3FC0_0000, 1'b0, 1'b1, rm[1:0]);
            drive(32'hBFC0_0000, 1'b1, 1'b1, rm[1:0]);
            drive(32'h402F_FFFF, 1'b1, 1'b1, rm[1:0]);
        end
        idle(3);
        // Random operands, half of them with exponents near the integer range.
        for (int i = 0; i < 2500; i++) begin
            a = $urandom;
            if (i % 2 == 1) a[30:23] = 8'(120 + $urandom_range(0, 45));
            drive(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule